// File: doc/BRIEF.md
# Prefetch Request Intake Arbiter

This block gathers prefetch requests from two kinds of sources and passes at most one per cycle to a single downstream prefetch pipeline. Several load ports can each raise a software prefetch hint. These ports have no backpressure. One of them is taken each cycle and parked in a one-entry buffer. A fetch-target queue supplies hardware prefetch requests through a valid/ready handshake. Each of those requests carries an address and a queue index.

The buffered software request always goes first. A hardware request waits, with its ready held low, until the buffer is empty and the output register can take a new entry. Software requests that lose arbitration between ports are dropped without notice. A stalled buffered request is replaced by a newer one. Every forwarded request carries a flag that tells software hints apart. The downstream pipeline only looks those up for miss or exception and never lets them reach the fetch path. A flush empties the buffer and the output register, and blocks all intake for that cycle.

Top module: `pf_intake_arb`

## Requirements
- R1: After reset, out_valid is 0, and hw_ready is 1 whenever flush is low.
- R2: When several software ports are valid in one cycle, only the lowest-indexed one (port 0 highest) is forwarded, and the others never appear on the output.
- R3: A software request that arrives while an earlier one is still buffered (output stalled) replaces it. Only the newest is forwarded, and the replaced one never appears.
- R4: While a software request is buffered, hw_ready is 0, and the buffered request leaves before a pending hardware request.
- R5: While out_valid is 1 and out_ready is 0, hw_ready is 0.
- R6: While flush is 1, hw_ready is 0 and software ports are ignored. In the cycle after a flush, out_valid is 0 and the buffer holds nothing.
- R7: out_is_sw is 1 for a forwarded software request, with out_idx equal to 0. It is 0 for a hardware request, with out_idx equal to that request's index.
- R8: While out_valid is 1, out_ready is 0 and flush is 0, the output entry stays unchanged in the next cycle.
- R9: A hardware request accepted on a clock edge is on the output right after that edge.
- R10: A software request raised on an edge with an empty path is on the output after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears buffer and output register, blocks intake |
| sw_valid | input | NUM_SW | Per-port software prefetch valid |
| sw_addr | input | NUM_SW*ADDR_W | Packed software addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| hw_valid | input | 1 | Hardware prefetch request valid |
| hw_ready | output | 1 | Hardware request accepted this cycle |
| hw_addr | input | ADDR_W | Hardware prefetch address |
| hw_idx | input | IDX_W | Queue index of hardware request |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Downstream pipeline accepts entry |
| out_addr | output | ADDR_W | Forwarded address |
| out_idx | output | IDX_W | Queue index (0 for software) |
| out_is_sw | output | 1 | Entry is a software prefetch |

## Verification
The bench builds the block with three software ports, 8-bit addresses and 4-bit indices. That makes it cheap to sweep all eight software-port valid patterns and compute the winning address arithmetically. The same small configuration lets directed sequences cover stalls, replacement in the buffer, software-over-hardware ordering and flushes with every source active. Each of these runs in a few cycles, and each checks that dropped requests never surface.

// File: rtl/pf_intake_pkg.sv
package pf_intake_pkg;
  typedef enum logic {
    SRC_HW = 1'b0,
    SRC_SW = 1'b1
  } pf_src_e;
endpackage

// File: rtl/pf_sw_pick.sv
module pf_sw_pick #(
  parameter int NUM_SW = 3,
  parameter int ADDR_W = 48
) (
  input  logic [NUM_SW-1:0]        req_vld,
  input  logic [NUM_SW*ADDR_W-1:0] req_addr,
  output logic                     pick_vld,
  output logic [ADDR_W-1:0]        pick_addr
);
  logic [ADDR_W-1:0] lane_addr [NUM_SW];
  logic [ADDR_W-1:0] chain     [NUM_SW+1];

  // Unpack each lane, then build a priority chain from the top lane down
  // so that the lowest valid index ends at chain[0].
  assign chain[NUM_SW] = '0;
  for (genvar g = 0; g < NUM_SW; g++) begin : g_lane
    assign lane_addr[g] = req_addr[g*ADDR_W +: ADDR_W];
    assign chain[g]     = req_vld[g] ? lane_addr[g] : chain[g+1];
  end

  assign pick_vld  = |req_vld;
  assign pick_addr = chain[0];
endmodule

// File: rtl/pf_sw_slot.sv
module pf_sw_slot #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              consume,
  output logic              slot_vld,
  output logic [ADDR_W-1:0] slot_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= 1'b0;
    end else if (flush) begin
      slot_vld <= 1'b0;
    end else if (in_vld) begin
      slot_vld  <= 1'b1;
      slot_addr <= in_addr;
    end else if (consume) begin
      slot_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_out_stage.sv
module pf_out_stage
  import pf_intake_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  pf_src_e           load_src,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic              out_ready,
  output logic              stage_free,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_is_sw
);
  assign stage_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (stage_free) begin
      out_valid <= load;
      if (load) begin
        out_addr  <= load_addr;
        out_is_sw <= (load_src == SRC_SW);
        out_idx   <= (load_src == SRC_SW) ? '0 : load_idx;
      end
    end
  end
endmodule

// File: rtl/pf_intake_arb.sv
module pf_intake_arb
  import pf_intake_pkg::*;
#(
  parameter int NUM_SW = 3,
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic [NUM_SW-1:0]        sw_valid,
  input  logic [NUM_SW*ADDR_W-1:0] sw_addr,
  input  logic                     hw_valid,
  output logic                     hw_ready,
  input  logic [ADDR_W-1:0]        hw_addr,
  input  logic [IDX_W-1:0]         hw_idx,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ADDR_W-1:0]        out_addr,
  output logic [IDX_W-1:0]         out_idx,
  output logic                     out_is_sw
);
  logic              pick_vld;
  logic [ADDR_W-1:0] pick_addr;
  logic              slot_vld;
  logic [ADDR_W-1:0] slot_addr;
  logic              stage_free;
  logic              sw_take;
  logic              load;
  pf_src_e           load_src;

  pf_sw_pick #(.NUM_SW(NUM_SW), .ADDR_W(ADDR_W)) u_pick (
    .req_vld  (sw_valid),
    .req_addr (sw_addr),
    .pick_vld (pick_vld),
    .pick_addr(pick_addr)
  );

  pf_sw_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .in_vld   (pick_vld),
    .in_addr  (pick_addr),
    .consume  (sw_take),
    .slot_vld (slot_vld),
    .slot_addr(slot_addr)
  );

  // The buffered software entry goes first; hardware waits for an empty slot.
  assign sw_take  = slot_vld && stage_free && !flush;
  assign hw_ready = !flush && stage_free && !slot_vld;
  assign load     = sw_take || (hw_valid && hw_ready);
  assign load_src = sw_take ? SRC_SW : SRC_HW;

  pf_out_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .load      (load),
    .load_src  (load_src),
    .load_addr (sw_take ? slot_addr : hw_addr),
    .load_idx  (hw_idx),
    .out_ready (out_ready),
    .stage_free(stage_free),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_idx   (out_idx),
    .out_is_sw (out_is_sw)
  );
endmodule

// File: rtl/pf_intake_chk.sv
module pf_intake_chk #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              hw_valid,
  input logic              hw_ready,
  input logic [ADDR_W-1:0] hw_addr,
  input logic [IDX_W-1:0]  hw_idx,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [IDX_W-1:0]  out_idx,
  input logic              out_is_sw
);
  // R5
  stall_blocks_hw_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !hw_ready);

  // R6
  flush_blocks_hw_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !hw_ready);

  // R6
  flush_empties_out_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  // R7
  sw_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_sw) |-> (out_idx == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_addr) && $stable(out_idx) && $stable(out_is_sw)));

  // R9
  hw_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_valid && hw_ready) |=>
      (out_valid && !out_is_sw && out_addr == $past(hw_addr) && out_idx == $past(hw_idx)));
endmodule

bind pf_intake_arb pf_intake_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .hw_valid (hw_valid),
  .hw_ready (hw_ready),
  .hw_addr  (hw_addr),
  .hw_idx   (hw_idx),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_addr (out_addr),
  .out_idx  (out_idx),
  .out_is_sw(out_is_sw)
);

// File: tb/pf_intake_arb_test.sv
`timescale 1ns/1ps
module pf_intake_arb_test;
  localparam int N  = 3;
  localparam int AW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst, flush, hw_valid, out_ready;
  logic [N-1:0]  sw_valid;
  logic [N*AW-1:0] sw_addr;
  logic [AW-1:0] hw_addr;
  logic [IW-1:0] hw_idx;
  logic          hw_ready, out_valid, out_is_sw;
  logic [AW-1:0] out_addr;
  logic [IW-1:0] out_idx;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pf_intake_arb #(.NUM_SW(N), .ADDR_W(AW), .IDX_W(IW)) uut (
    .clk(clk), .rst(rst), .flush(flush),
    .sw_valid(sw_valid), .sw_addr(sw_addr),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_addr(hw_addr), .hw_idx(hw_idx),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_idx(out_idx), .out_is_sw(out_is_sw)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    rst = 1; flush = 0; hw_valid = 0; out_ready = 1;
    sw_valid = '0; sw_addr = '0; hw_addr = '0; hw_idx = '0;
    tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(hw_ready == 1, "R1 hw_ready", hw_ready, 1);

    // R2 / R10 sweep of all software valid patterns
    for (int p = 0; p < 8; p++) begin
      int low;
      low = (p & 1) ? 0 : (p & 2) ? 1 : 2;
      sw_valid = p[N-1:0];
      for (int i = 0; i < N; i++) sw_addr[i*AW +: AW] = 8'(p*16 + i);
      tick();
      sw_valid = '0;
      chk(out_valid == 0, "R10 not before second edge", out_valid, 0);
      tick();
      if (p != 0) begin
        chk(out_valid && out_is_sw, "R10 sw on output", out_valid, 1);
        chk(out_addr == 8'(p*16 + low), "R2 lowest port wins", out_addr, p*16 + low);
        chk(out_idx == 0, "R7 sw idx zero", out_idx, 0);
      end else begin
        chk(out_valid == 0, "R2 no request", out_valid, 0);
      end
      tick();
      chk(out_valid == 0, "R2 losers dropped", out_valid, 0);
    end

    // R9 / R7 hardware stream back to back
    for (int k = 0; k < 6; k++) begin
      hw_valid = 1; hw_addr = 8'(200 + k); hw_idx = 4'(k + 1);
      chk(hw_ready == 1, "R9 hw ready", hw_ready, 1);
      tick();
      chk(out_valid && !out_is_sw, "R7 hw flag", out_is_sw, 0);
      chk(out_addr == 8'(200 + k), "R9 hw addr", out_addr, 200 + k);
      chk(out_idx == 4'(k + 1), "R7 hw idx", out_idx, k + 1);
    end
    hw_valid = 0;
    tick();

    // R4 buffered software beats pending hardware
    sw_valid = 3'b100; sw_addr[2*AW +: AW] = 8'h55;
    tick();
    sw_valid = '0;
    hw_valid = 1; hw_addr = 8'h66; hw_idx = 4'd3;
    chk(hw_ready == 0, "R4 hw blocked by buffer", hw_ready, 0);
    tick();
    chk(out_valid && out_is_sw && out_addr == 8'h55, "R4 sw first", out_addr, 8'h55);
    chk(hw_ready == 1, "R4 hw ready after drain", hw_ready, 1);
    tick();
    hw_valid = 0;
    chk(out_valid && !out_is_sw && out_addr == 8'h66, "R4 hw second", out_addr, 8'h66);
    tick();

    // R3 / R5 / R8 replacement while stalled
    out_ready = 0;
    hw_valid = 1; hw_addr = 8'h70; hw_idx = 4'd9;
    tick();
    sw_valid = 3'b001; sw_addr[0 +: AW] = 8'h11;
    chk(hw_ready == 0, "R5 hw blocked on stall", hw_ready, 0);
    tick();
    sw_valid = 3'b010; sw_addr[AW +: AW] = 8'h22;
    tick();
    sw_valid = '0; hw_valid = 0;
    chk(out_valid && out_addr == 8'h70 && out_idx == 4'd9, "R8 held", out_addr, 8'h70);
    out_ready = 1;
    tick();
    chk(out_valid && out_is_sw && out_addr == 8'h22, "R3 newest forwarded", out_addr, 8'h22);
    tick();
    chk(out_valid == 0, "R3 replaced never seen", out_valid, 0);

    // R6 flush with everything active
    out_ready = 0;
    sw_valid = 3'b001; sw_addr[0 +: AW] = 8'h33;
    tick();
    tick();
    sw_valid = 3'b001; sw_addr[0 +: AW] = 8'h44;
    hw_valid = 1; hw_addr = 8'h77;
    flush = 1;
    chk(hw_ready == 0, "R6 hw blocked in flush", hw_ready, 0);
    tick();
    flush = 0; sw_valid = '0; hw_valid = 0; out_ready = 1;
    chk(out_valid == 0, "R6 output cleared", out_valid, 0);
    tick();
    chk(out_valid == 0, "R6 buffer cleared", out_valid, 0);
    tick();
    chk(out_valid == 0, "R6 flush-time sw ignored", out_valid, 0);

    summary();
  end
endmodule